// File: doc/BRIEF.md
# Windowed Watchdog Timer with Control Lock

This block is a watchdog timer that sits on a simple 32-bit register bus. A counter advances while two control bits are both set. It is compared against three programmable limits: an interrupt limit, a reset limit and an early-service limit. Software proves it is alive by writing a two-word service sequence to the service register. If it fails to do so before a limit is reached, the matching status flag rises. If it completes the sequence before the early-service limit, a separate early-service flag rises. Each flag can be routed to the interrupt line, and the reset flag can be routed to a one-cycle reset pulse.

A key register locks the control register, so that errant code cannot silently disable or reprogram the timer. Every limit is a power of two selected by a 4-bit code. The parameter `SCALE_SHIFT` divides all limits by the same power of two, so that short runs can reach every code with the same decode logic. The default of 16 gives a limit of 2^(15-code) cycles, and a value of 0 gives the full 2^(31-code) range.

Top module: `wdw_top`

## Requirements
- R1: Register offsets: control 0x00, service 0x04, status 0x08, routing 0x0C, key 0x14 (0x10 and others read zero). After reset the control, status and routing registers read 0, the key register reads 0 (unlocked), `irq` is 0 and `rst_pulse` is 0.
- R2: The counter advances by one per cycle only while control bit 8 and control bit 9 are both 1. With either bit clear it holds and no flag is raised.
- R3: A code n selects a limit of 2^(31-SCALE_SHIFT-n) cycles. The interrupt code sits in control [3:0]. Status bit 0 (timeout) sets on the clock edge at which the counter advances to the interrupt limit.
- R4: The reset code sits in control [7:4]. Status bit 2 sets on the edge at which the counter advances to the reset limit. On that same edge `rst_pulse` goes high for exactly one cycle if routing bit 2 is 1.
- R5: Writing 0xA5 and then 0x5A to the service register clears the counter. A write of any other value to that register between the two aborts the sequence, and the 0x5A is then not a service.
- R6: The early code sits in control [15:12]. A service completed while the counter is below the early limit sets status bit 1 and still clears the counter.
- R7: `irq` is high exactly when (status bit 0 and routing bit 0) or (status bit 1 and routing bit 1).
- R8: Status bits are write-one-to-clear at offset 0x08. A bit that is set and cleared in the same cycle ends up set.
- R9: Writing 0x24 to key bits [7:0] locks the control register, and 0x42 unlocks it. Other values leave the lock state unchanged. While locked, control writes are ignored. Key bit 0 reads back 1 while locked.
- R10: When a service completes in the cycle in which the counter would otherwise reach a limit, the service wins: the counter clears and no limit flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when 1 with bus_sel |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Routed interrupt level |
| rst_pulse | output | 1 | One-cycle reset request |

## Verification
The service completion and a limit crossing can fall in the same cycle. A sweep provokes this by placing the closing 0x5A write at a range of distances from the interrupt limit, including the exact cycle in which the counter would land on it. Each outcome is judged by the timeout status bit. A write-one-to-clear can also coincide with a flag being set. A cycle-accurate behavioural model in the bench tracks both cases and compares `irq` and `rst_pulse` on every clock.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  localparam logic [7:0]  OFS_CTL  = 8'h00;
  localparam logic [7:0]  OFS_SVC  = 8'h04;
  localparam logic [7:0]  OFS_STAT = 8'h08;
  localparam logic [7:0]  OFS_ROUT = 8'h0C;
  localparam logic [7:0]  OFS_KEY  = 8'h14;
  localparam logic [7:0]  KEY_CLOSE = 8'h24;
  localparam logic [7:0]  KEY_OPEN  = 8'h42;
  localparam logic [31:0] SVC_FIRST  = 32'h0000_00A5;
  localparam logic [31:0] SVC_SECOND = 32'h0000_005A;
  localparam logic [31:0] CTL_MASK   = 32'h0000_F3FF;
  localparam int NUM_LIM = 3;   // 0: interrupt, 1: reset, 2: early

  typedef struct packed {
    logic rst_hit;   // bit 2
    logic early;     // bit 1
    logic tmo;       // bit 0
  } wdw_flags_t;
endpackage

// File: rtl/wdw_svc.sv
module wdw_svc
  import wdw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_svc,
  input  logic [31:0] wdata,
  output logic        svc_ok
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    svc_ok  = 1'b0;
    if (wr_svc) begin
      svc_ok  = armed_q && (wdata == SVC_SECOND);
      armed_d = (wdata == SVC_FIRST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (wr_svc) armed_q <= armed_d;
  end

  // R5: an aborting value drops the armed state
  assert_abort_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_svc && wdata != SVC_FIRST) |=> !armed_q);
endmodule

// File: rtl/wdw_count.sv
module wdw_count
  import wdw_pkg::*;
#(
  parameter int SCALE_SHIFT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic                       svc_ok,
  input  logic [NUM_LIM-1:0][3:0]    codes,
  output logic                       hit_tmo,
  output logic                       hit_rst,
  output logic                       too_early
);
  localparam int CNT_W   = 32 - SCALE_SHIFT;
  localparam int LOG_TOP = 31 - SCALE_SHIFT;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [NUM_LIM-1:0][CNT_W-1:0] lim;
  logic adv;

  for (genvar i = 0; i < NUM_LIM; i++) begin : g_lim
    always_comb lim[i] = CNT_W'(1) << (LOG_TOP - int'(codes[i]));
  end

  always_comb begin
    adv     = run && !svc_ok;
    cnt_inc = (cnt_q == {CNT_W{1'b1}}) ? cnt_q : cnt_q + CNT_W'(1);
    cnt_d   = svc_ok ? '0 : (adv ? cnt_inc : cnt_q);
    hit_tmo   = adv && (cnt_inc == lim[0]);
    hit_rst   = adv && (cnt_inc == lim[1]);
    too_early = svc_ok && (cnt_q < lim[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (svc_ok || adv) cnt_q <= cnt_d;
  end

  assert_svc_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> (cnt_q == '0));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !svc_ok) |=> $stable(cnt_q));
  assert_svc_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |-> !(hit_tmo || hit_rst));
endmodule

// File: rtl/wdw_flags.sv
module wdw_flags
  import wdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wdw_flags_t set_v,
  input  logic       clr_en,
  input  logic [2:0] clr_v,
  input  logic [2:0] route,
  output wdw_flags_t flags,
  output logic       irq,
  output logic       rst_pulse
);
  wdw_flags_t flags_d;
  logic       pulse_d;

  always_comb begin
    flags_d = flags;
    if (clr_en) flags_d = wdw_flags_t'(flags & ~clr_v);
    flags_d = wdw_flags_t'(flags_d | set_v);
    pulse_d = set_v.rst_hit && route[2];
    irq     = (flags.tmo && route[0]) || (flags.early && route[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags     <= '0;
      rst_pulse <= 1'b0;
    end else begin
      flags     <= flags_d;
      rst_pulse <= pulse_d;
    end
  end

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_v.tmo |=> flags.tmo);
  assert_early_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_v.early |=> flags.early);
endmodule

// File: rtl/wdw_top.sv
module wdw_top
  import wdw_pkg::*;
#(
  parameter int SCALE_SHIFT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        rst_pulse
);
  logic [31:0] ctl_q, ctl_d;
  logic [2:0]  rout_q, rout_d;
  logic        lock_q, lock_d;
  logic        wr, wr_ctl, wr_svc, wr_stat, wr_rout, wr_key;
  logic        svc_ok, hit_tmo, hit_rst, too_early;
  wdw_flags_t  flags, set_v;
  logic [NUM_LIM-1:0][3:0] codes;

  always_comb begin
    wr      = bus_sel && bus_wr;
    wr_ctl  = wr && (bus_addr == OFS_CTL);
    wr_svc  = wr && (bus_addr == OFS_SVC);
    wr_stat = wr && (bus_addr == OFS_STAT);
    wr_rout = wr && (bus_addr == OFS_ROUT);
    wr_key  = wr && (bus_addr == OFS_KEY);
    ctl_d   = (wr_ctl && !lock_q) ? (bus_wdata & CTL_MASK) : ctl_q;
    rout_d  = wr_rout ? bus_wdata[2:0] : rout_q;
    lock_d  = lock_q;
    if (wr_key && bus_wdata[7:0] == KEY_CLOSE) lock_d = 1'b1;
    if (wr_key && bus_wdata[7:0] == KEY_OPEN)  lock_d = 1'b0;
    codes[0] = ctl_q[3:0];
    codes[1] = ctl_q[7:4];
    codes[2] = ctl_q[15:12];
    set_v    = '{rst_hit: hit_rst, early: too_early, tmo: hit_tmo};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      rout_q <= '0;
      lock_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      rout_q <= rout_d;
      lock_q <= lock_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CTL:  bus_rdata = ctl_q;
      OFS_STAT: bus_rdata = {29'b0, flags};
      OFS_ROUT: bus_rdata = {29'b0, rout_q};
      OFS_KEY:  bus_rdata = {31'b0, lock_q};
      default:  bus_rdata = '0;
    endcase
  end

  wdw_svc u_svc (
    .clk(clk), .rst_n(rst_n), .wr_svc(wr_svc), .wdata(bus_wdata), .svc_ok(svc_ok)
  );

  wdw_count #(.SCALE_SHIFT(SCALE_SHIFT)) u_count (
    .clk(clk), .rst_n(rst_n), .run(ctl_q[8] && ctl_q[9]), .svc_ok(svc_ok),
    .codes(codes), .hit_tmo(hit_tmo), .hit_rst(hit_rst), .too_early(too_early)
  );

  wdw_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_en(wr_stat),
    .clr_v(bus_wdata[2:0]), .route(rout_q), .flags(flags),
    .irq(irq), .rst_pulse(rst_pulse)
  );

  assert_locked_ctl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_ctl) |=> $stable(ctl_q));
  assert_lock_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && bus_wdata[7:0] == KEY_CLOSE) |=> lock_q);
endmodule

// File: tb/wdw_top_tb.sv
module wdw_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_pulse;

  int total = 0, bad = 0, cycles = 0, pulses = 0;
  bit done = 0;

  wdw_top u_dut (.*);

  always #10 clk = ~clk;   // 50 MHz

  // behavioural reference model
  int m_cnt, m_flags, m_ctl, m_rout, m_lock, m_arm, m_pulse;
  function automatic int lim(int code);
    return 1 << (15 - code);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_flags = 0; m_ctl = 0; m_rout = 0; m_lock = 0; m_arm = 0; m_pulse = 0;
    end else begin
      int w, a, d, ncnt, setv, clrv;
      bit svc, adv;
      w = bus_sel && bus_wr; a = bus_addr; d = bus_wdata;
      svc = w && a == 4 && d == 'h5A && m_arm;
      adv = ((m_ctl >> 8) & 3) == 3 && !svc;
      ncnt = svc ? 0 : (adv ? (m_cnt == 65535 ? m_cnt : m_cnt + 1) : m_cnt);
      setv = 0;
      if (adv && ncnt == lim(m_ctl & 15)) setv |= 1;
      if (adv && ncnt == lim((m_ctl >> 4) & 15)) setv |= 4;
      if (svc && m_cnt < lim((m_ctl >> 12) & 15)) setv |= 2;
      clrv = (w && a == 8) ? (d & 7) : 0;
      m_pulse = ((setv & 4) != 0) && ((m_rout & 4) != 0);
      m_flags = (m_flags & ~clrv) | setv;
      m_cnt = ncnt;
      if (w && a == 4) m_arm = (d == 'hA5);
      if (w && a == 'h0C) m_rout = d & 7;
      if (w && a == 0 && !m_lock) m_ctl = d & 'hF3FF;
      if (w && a == 'h14 && (d & 255) == 'h24) m_lock = 1;
      if (w && a == 'h14 && (d & 255) == 'h42) m_lock = 0;
    end
  end

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      int mi;
      mi = ((m_flags & m_rout & 3) != 0);
      chk("R7 irq per-cycle", irq, mi);
      chk("R4 rst_pulse per-cycle", rst_pulse, m_pulse);
      if (rst_pulse) pulses++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic service();
    wr(8'h04, 32'hA5); wr(8'h04, 32'h5A);
  endtask

  initial begin : watchdog
    wait (cycles > 20000);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    rd(8'h00, v); chk("R1 ctl", v, 0);
    rd(8'h08, v); chk("R1 stat", v, 0);
    rd(8'h14, v); chk("R1 key", v, 0);
    rd(8'h10, v); chk("R1 reserved", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst_pulse", rst_pulse, 0);
    // R2 only one enable bit set: no counting
    wr(8'h00, 32'h0000_01FF); idle(10);
    rd(8'h08, v); chk("R2 run only", v, 0);
    wr(8'h00, 32'h0000_02FF); idle(10);
    rd(8'h08, v); chk("R2 tick only", v, 0);
    // R3/R4: early 13 (4), reset 11 (16), interrupt 12 (8), both enables
    wr(8'h0C, 32'h5);
    wr(8'h00, 32'h0000_D3BC); idle(12);
    rd(8'h08, v); chk("R3 timeout flag", v, 1);
    chk("R7 irq routed timeout", irq, 1);
    idle(10);
    rd(8'h08, v); chk("R4 reset flag", v, 5);
    chk("R4 single pulse", pulses, 1);
    // R8 write-one-to-clear
    wr(8'h08, 32'h1);
    rd(8'h08, v); chk("R8 clear bit0 only", v, 4);
    chk("R7 irq after clear", irq, 0);
    wr(8'h08, 32'h4);
    rd(8'h08, v); chk("R8 clear bit2", v, 0);
    // R5 service keeps timer from expiring
    service(); idle(5); service(); idle(5);
    rd(8'h08, v); chk("R5 serviced no timeout", v, 0);
    wr(8'h04, 32'hA5); wr(8'h04, 32'h11); wr(8'h04, 32'h5A); idle(8);
    rd(8'h08, v); chk("R5 aborted sequence", v & 1, 1);
    // R6 early service
    wr(8'h08, 32'h7);
    service(); service();
    rd(8'h08, v); chk("R6 early flag", v, 2);
    wr(8'h0C, 32'h2);
    chk("R7 irq routed early", irq, 1);
    idle(4);
    rd(8'h08, v); chk("R6 counter cleared", v, 2);
    wr(8'h0C, 32'h0);
    chk("R7 irq unrouted", irq, 0);
    // R9 lock
    wr(8'h14, 32'h24);
    rd(8'h14, v); chk("R9 locked", v, 1);
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R9 ctl ignored", v, 32'hD3BC);
    wr(8'h14, 32'h99);
    rd(8'h14, v); chk("R9 other key", v, 1);
    wr(8'h14, 32'h42);
    rd(8'h14, v); chk("R9 unlocked", v, 0);
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R9 ctl written", v, 0);
    wr(8'h00, 32'h0000_D3BC);
    // R10 service vs interrupt limit in the same cycle
    for (int n = 3; n <= 8; n++) begin
      service();
      wr(8'h08, 32'h7);
      wr(8'h04, 32'hA5);
      idle(n);
      wr(8'h04, 32'h5A);
      rd(8'h08, v); chk($sformatf("R10 gap %0d", n), v & 1, (n >= 6) ? 1 : 0);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule